// File: doc/BRIEF.md
# Masked Symbol Sequence Recognizer

This block watches a stream of decoded 9-bit link symbols, eight data bits with a control flag in bit 8, and reports when a programmed run of up to sixteen symbols has gone past. Every step of the run carries its own bit mask and compare value, so a step can demand an exact symbol, a class of symbols, or anything at all. It feeds a trigger sequencer, which sees the recognizer's hit as one of its event inputs.

Two per-step options change how the search moves. A step marked hold keeps the search parked on that step while unrelated symbols stream past, instead of throwing away the progress made so far. A step marked invert succeeds on every symbol that fails its compare. The steps are written one at a time through a plain write port, and a separate write sets how many of the sixteen steps are in use. A link-not-aligned input parks the search at its start and blocks hits.

Top module: `symseq_match`

## Requirements
- R1: After reset the search sits at step 0, the run length is 16, and every step has mask 0, value 0, hold off and invert off, so every symbol passes and the first hit comes on the 16th accepted symbol.
- R2: A step passes a symbol when (symbol AND mask) equals (value AND mask) over all 9 bits, bit 8 being the control flag; bits with a mask of 0 are ignored.
- R3: When the current step passes and is the last step of the run (index length-1), `hit` is high in that same cycle, combinationally from the inputs, and the search returns to step 0; when a step other than the last passes, the search moves to the next step.
- R4: When the current step fails and is not marked hold, the same symbol is tested against step 0 in that cycle; if it passes there the search moves to step 1, or hits at once when the length is 1, and otherwise it returns to step 0.
- R5: When the current step fails and is marked hold, the search stays on that step.
- R6: A step marked invert passes exactly the symbols that fail its mask-and-value compare.
- R7: A cycle with `sym_valid` low changes neither the step nor the length and gives no hit.
- R8: While `link_unaligned` is high there is no hit and the search returns to step 0 at the next edge, whatever the symbol.
- R9: A length write sets the run length to `len_val`, with 0 taken as 1 and values above 16 taken as 16, and returns the search to step 0.
- R10: A step write stores mask, value, hold and invert for step `cfg_idx` and returns the search to step 0; a symbol presented in a cycle with a step write or length write is dropped and gives no hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_valid | input | 1 | Symbol present this cycle |
| sym_data | input | 9 | Symbol, bit 8 is the control flag |
| link_unaligned | input | 1 | Disqualify: park at step 0, no hit |
| cfg_we | input | 1 | Step write strobe |
| cfg_idx | input | 4 | Step being written |
| cfg_mask | input | 9 | Mask for that step |
| cfg_value | input | 9 | Compare value for that step |
| cfg_hold | input | 1 | Hold on mismatch for that step |
| cfg_invert | input | 1 | Invert the compare for that step |
| len_we | input | 1 | Length write strobe |
| len_val | input | 5 | Run length, 1 to 16 |
| hit | output | 1 | Run completed this cycle |

## Verification
The hit is combinational: it belongs to the cycle in which the final symbol is on the inputs, so the bench drives each symbol just after a falling edge and samples `hit` one nanosecond later, before the rising edge that moves the step register. Step and length writes take effect at the rising edge that follows their strobe, so the first symbol after a write is judged against the new settings and a fresh step 0. Every fed symbol, directed or swept, is compared with a bench model of the requirements in that same sampling slot, and the directed cases also carry a hand-worked expected value.

// File: rtl/symseq_pkg.sv
// Shared constants and types for the symbol sequence recognizer.
// Assumes a 9-bit symbol with the control flag in the top bit.
package symseq_pkg;
    localparam int SYM_BITS  = 9;
    localparam int MAX_STEPS = 16;

    // What the search does with one accepted symbol.
    typedef enum logic [2:0] {
        ACT_ADVANCE  = 3'd0,   // current step passed, not last
        ACT_FINISH   = 3'd1,   // run complete, report hit
        ACT_HOLD     = 3'd2,   // failed on a hold step
        ACT_RESTART1 = 3'd3,   // failed, but step 0 accepts the symbol
        ACT_RESTART0 = 3'd4    // failed everywhere, back to start
    } step_act_e;
endpackage

// File: rtl/symseq_bank.sv
// Per-step configuration storage with one write port and two read ports
// (the current step and step 0). Assumes wr_idx is below STEPS.
module symseq_bank #(
    parameter int SYM_W = 9,
    parameter int STEPS = 16,
    localparam int IDX_W = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [SYM_W-1:0] wr_mask,
    input  logic [SYM_W-1:0] wr_value,
    input  logic             wr_hold,
    input  logic             wr_invert,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [SYM_W-1:0] cur_mask,
    output logic [SYM_W-1:0] cur_value,
    output logic             cur_hold,
    output logic             cur_invert,
    output logic [SYM_W-1:0] zero_mask,
    output logic [SYM_W-1:0] zero_value,
    output logic             zero_invert
);
    logic [STEPS-1:0][SYM_W-1:0] mask_all;
    logic [STEPS-1:0][SYM_W-1:0] value_all;
    logic [STEPS-1:0]            hold_all;
    logic [STEPS-1:0]            inv_all;

    for (genvar g = 0; g < STEPS; g++) begin : g_step
        logic [SYM_W-1:0] mask_q;
        logic [SYM_W-1:0] value_q;
        logic             hold_q;
        logic             inv_q;

        // Hold this step's settings, cleared to "pass anything" on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q  <= '0;
                value_q <= '0;
                hold_q  <= 1'b0;
                inv_q   <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                mask_q  <= wr_mask;
                value_q <= wr_value;
                hold_q  <= wr_hold;
                inv_q   <= wr_invert;
            end
        end

        assign mask_all[g]  = mask_q;
        assign value_all[g] = value_q;
        assign hold_all[g]  = hold_q;
        assign inv_all[g]   = inv_q;
    end

    // Read the current step and the fixed restart step.
    always_comb begin
        cur_mask    = mask_all[rd_idx];
        cur_value   = value_all[rd_idx];
        cur_hold    = hold_all[rd_idx];
        cur_invert  = inv_all[rd_idx];
        zero_mask   = mask_all[0];
        zero_value  = value_all[0];
        zero_invert = inv_all[0];
    end
endmodule

// File: rtl/symseq_cmp.sv
// Masked compare of one symbol against one step, with optional inversion.
// Purely combinational.
module symseq_cmp #(
    parameter int SYM_W = 9
) (
    input  logic [SYM_W-1:0] sym,
    input  logic [SYM_W-1:0] mask,
    input  logic [SYM_W-1:0] value,
    input  logic             invert,
    output logic             pass
);
    // Differences only count where the mask has a 1.
    always_comb pass = (((sym ^ value) & mask) == '0) ^ invert;
endmodule

// File: rtl/symseq_ctrl.sv
// Search position and run length. Decides per accepted symbol whether to
// advance, finish, hold or restart. Assumes compare results for the current
// step and step 0 arrive combinationally in the same cycle.
module symseq_ctrl
    import symseq_pkg::*;
#(
    parameter int STEPS = 16,
    localparam int IDX_W = $clog2(STEPS),
    localparam int LEN_W = $clog2(STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic             disq,
    input  logic             cfg_we,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_val,
    input  logic             cur_pass,
    input  logic             cur_hold,
    input  logic             zero_pass,
    output logic [IDX_W-1:0] pos,
    output logic [LEN_W-1:0] len,
    output logic             hit
);
    localparam logic [LEN_W-1:0] LEN_MAX = LEN_W'(STEPS);
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    step_act_e        act;
    logic             accept;
    logic             at_last;
    logic [LEN_W-1:0] len_clamped;

    // Pick the action for the symbol on the inputs.
    always_comb begin
        at_last = (LEN_W'(pos) == len - LEN_ONE);
        if (cur_pass)
            act = at_last ? ACT_FINISH : ACT_ADVANCE;
        else if (cur_hold)
            act = ACT_HOLD;
        else if (zero_pass)
            act = (len == LEN_ONE) ? ACT_FINISH : ACT_RESTART1;
        else
            act = ACT_RESTART0;
    end

    // A symbol counts only when valid, qualified and not colliding with a write.
    always_comb begin
        accept = sym_valid && !disq && !cfg_we && !len_we;
        hit    = accept && (act == ACT_FINISH);
    end

    // Limit a written length to the 1..STEPS range.
    always_comb begin
        if (len_val == '0)
            len_clamped = LEN_ONE;
        else if (len_val > LEN_MAX)
            len_clamped = LEN_MAX;
        else
            len_clamped = len_val;
    end

    // Update the run length and the search position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
            len <= LEN_MAX;
        end else begin
            if (len_we)
                len <= len_clamped;
            if (disq || cfg_we || len_we) begin
                pos <= '0;
            end else if (sym_valid) begin
                case (act)
                    ACT_ADVANCE:  pos <= pos + 1'b1;
                    ACT_RESTART1: pos <= IDX_W'(1);
                    ACT_HOLD:     pos <= pos;
                    default:      pos <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/symseq_match.sv
// Top of the masked symbol sequence recognizer. Wires the step bank, two
// comparators (current step and step 0) and the search controller.
// Assumes one symbol per clock at most; hit is combinational from inputs.
module symseq_match
    import symseq_pkg::*;
#(
    parameter int SYM_W = SYM_BITS,
    parameter int STEPS = MAX_STEPS,
    localparam int IDX_W = $clog2(STEPS),
    localparam int LEN_W = $clog2(STEPS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    input  logic             link_unaligned,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [SYM_W-1:0] cfg_mask,
    input  logic [SYM_W-1:0] cfg_value,
    input  logic             cfg_hold,
    input  logic             cfg_invert,
    input  logic             len_we,
    input  logic [LEN_W-1:0] len_val,
    output logic             hit
);
    logic [IDX_W-1:0] cur_pos;
    logic [LEN_W-1:0] cur_len;
    logic [SYM_W-1:0] cur_mask, cur_value, zero_mask, zero_value;
    logic             cur_hold, cur_invert, zero_invert;
    logic             cur_pass, zero_pass;

    symseq_bank #(.SYM_W(SYM_W), .STEPS(STEPS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_we),
        .wr_idx     (cfg_idx),
        .wr_mask    (cfg_mask),
        .wr_value   (cfg_value),
        .wr_hold    (cfg_hold),
        .wr_invert  (cfg_invert),
        .rd_idx     (cur_pos),
        .cur_mask   (cur_mask),
        .cur_value  (cur_value),
        .cur_hold   (cur_hold),
        .cur_invert (cur_invert),
        .zero_mask  (zero_mask),
        .zero_value (zero_value),
        .zero_invert(zero_invert)
    );

    symseq_cmp #(.SYM_W(SYM_W)) u_cmp_cur (
        .sym   (sym_data),
        .mask  (cur_mask),
        .value (cur_value),
        .invert(cur_invert),
        .pass  (cur_pass)
    );

    symseq_cmp #(.SYM_W(SYM_W)) u_cmp_zero (
        .sym   (sym_data),
        .mask  (zero_mask),
        .value (zero_value),
        .invert(zero_invert),
        .pass  (zero_pass)
    );

    symseq_ctrl #(.STEPS(STEPS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sym_valid(sym_valid),
        .disq     (link_unaligned),
        .cfg_we   (cfg_we),
        .len_we   (len_we),
        .len_val  (len_val),
        .cur_pass (cur_pass),
        .cur_hold (cur_hold),
        .zero_pass(zero_pass),
        .pos      (cur_pos),
        .len      (cur_len),
        .hit      (hit)
    );
endmodule

// File: rtl/symseq_match_chk.sv
// Protocol checks on the recognizer's ports and search state.
module symseq_match_chk #(
    parameter int IDX_W = 4,
    parameter int LEN_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sym_valid,
    input logic             link_unaligned,
    input logic             cfg_we,
    input logic             len_we,
    input logic             hit,
    input logic [IDX_W-1:0] cur_pos,
    input logic [LEN_W-1:0] cur_len
);
    AST_HIT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (sym_valid && !link_unaligned)); // R8
    AST_HIT_NOT_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (!cfg_we && !len_we)); // R10
    AST_DISQ_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        link_unaligned |=> (cur_pos == '0)); // R8
    AST_GAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!sym_valid && !link_unaligned && !cfg_we && !len_we)
        |=> ($stable(cur_pos) && $stable(cur_len))); // R7
    AST_HIT_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cur_pos == '0)); // R3
    AST_WRITE_TO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we || len_we) |=> (cur_pos == '0)); // R9
    AST_POS_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        LEN_W'(cur_pos) < cur_len); // R9
endmodule

bind symseq_match symseq_match_chk #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_symseq_match.sv
module sim_symseq_match;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [8:0] sym_data = '0;
    logic       link_unaligned = 1'b0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_idx = '0;
    logic [8:0] cfg_mask = '0;
    logic [8:0] cfg_value = '0;
    logic       cfg_hold = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       len_we = 1'b0;
    logic [4:0] len_val = '0;
    logic       hit;

    int checks = 0;
    int errors = 0;

    // Bench model of the configured run and search position.
    logic [8:0] m_mask [16];
    logic [8:0] m_val  [16];
    logic       m_hold [16];
    logic       m_inv  [16];
    int         m_len = 16;
    int         m_pos = 0;

    localparam logic [8:0] SA = 9'h1BC;
    localparam logic [8:0] SB = 9'h041;
    localparam logic [8:0] SC = 9'h0F0;
    localparam logic [8:0] SX = 9'h033;

    always #4 clk = ~clk;

    symseq_match u0 (.*);

    function automatic logic passes(int s, logic [8:0] d);
        return ((((d ^ m_val[s]) & m_mask[s]) == 9'h000) ? 1'b1 : 1'b0) ^ m_inv[s];
    endfunction

    // Returns {hit, next position} for one cycle of inputs.
    function automatic logic [5:0] predict(logic v, logic [8:0] d, logic q);
        if (q) return 6'd0;
        if (!v) return {1'b0, 5'(m_pos)};
        if (passes(m_pos, d)) begin
            if (m_pos == m_len - 1) return {1'b1, 5'd0};
            return {1'b0, 5'(m_pos + 1)};
        end
        if (m_hold[m_pos]) return {1'b0, 5'(m_pos)};
        if (passes(0, d)) begin
            if (m_len == 1) return {1'b1, 5'd0};
            return {1'b0, 5'd1};
        end
        return 6'd0;
    endfunction

    task automatic check(logic got, logic want, string tag);
        checks++;
        if (got !== want) begin
            errors++;
            $display("FAIL %s: hit=%b expected %b at %0t", tag, got, want, $time);
        end
    endtask

    // One symbol cycle; exp < 0 means take the model's answer only.
    task automatic feed(logic v, logic [8:0] d, logic q, int exp, string tag);
        logic [5:0] r;
        @(negedge clk);
        sym_valid = v; sym_data = d; link_unaligned = q;
        cfg_we = 1'b0; len_we = 1'b0;
        #1;
        r = predict(v, d, q);
        check(hit, r[5], {tag, " model"});
        if (exp >= 0) check(hit, exp[0], tag);
        m_pos = int'(r[4:0]);
    endtask

    task automatic wr_step(int idx, logic [8:0] mk, logic [8:0] vl, logic hd, logic iv);
        @(negedge clk);
        sym_valid = 1'b0; link_unaligned = 1'b0; len_we = 1'b0;
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_mask = mk; cfg_value = vl;
        cfg_hold = hd; cfg_invert = iv;
        m_mask[idx] = mk; m_val[idx] = vl; m_hold[idx] = hd; m_inv[idx] = iv;
        m_pos = 0;
    endtask

    task automatic wr_len(int n);
        @(negedge clk);
        sym_valid = 1'b0; link_unaligned = 1'b0; cfg_we = 1'b0;
        len_we = 1'b1; len_val = 5'(n);
        m_len = (n == 0) ? 1 : ((n > 16) ? 16 : n);
        m_pos = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_mask[i] = '0; m_val[i] = '0; m_hold[i] = 1'b0; m_inv[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle after reset, then all-pass run of 16
        feed(0, SX, 0, 0, "R1 reset idle");
        for (int i = 0; i < 15; i++) feed(1, 9'(i * 7), 0, 0, "R1 default run");
        feed(1, SX, 0, 1, "R1 16th symbol hits");

        // Program A,B,C run of three
        wr_step(0, 9'h1FF, SA, 0, 0);
        wr_step(1, 9'h1FF, SB, 0, 0);
        wr_step(2, 9'h1FF, SC, 0, 0);
        wr_step(3, 9'h000, 9'h000, 0, 0);
        wr_len(3);

        // R3: exact run hits on its last symbol
        feed(1, SA, 0, 0, "R3"); feed(1, SB, 0, 0, "R3"); feed(1, SC, 0, 1, "R3 last");
        // R4: broken run restarts
        feed(1, SA, 0, 0, "R4"); feed(1, SB, 0, 0, "R4");
        feed(1, SX, 0, 0, "R4 break"); feed(1, SC, 0, 0, "R4 no hit");
        // R4: failing symbol re-tested at step 0
        feed(1, SA, 0, 0, "R4"); feed(1, SA, 0, 0, "R4 retest");
        feed(1, SB, 0, 0, "R4"); feed(1, SC, 0, 1, "R4 retest hit");

        // R7: gaps hold position
        feed(1, SA, 0, 0, "R7"); feed(0, SX, 0, 0, "R7 gap"); feed(0, SA, 0, 0, "R7 gap");
        feed(1, SB, 0, 0, "R7"); feed(0, SC, 0, 0, "R7 gap"); feed(1, SC, 0, 1, "R7 hit");

        // R2: mask on low nibble of last step, control flag ignored
        wr_step(2, 9'h00F, 9'h005, 0, 0);
        feed(1, SA, 0, 0, "R2"); feed(1, SB, 0, 0, "R2"); feed(1, 9'h1A5, 0, 1, "R2 masked hit");
        feed(1, SA, 0, 0, "R2"); feed(1, SB, 0, 0, "R2"); feed(1, 9'h0A4, 0, 0, "R2 masked miss");
        wr_step(2, 9'h1FF, SC, 0, 0);

        // R5: hold step waits through unrelated symbols
        wr_step(1, 9'h1FF, SB, 1, 0);
        feed(1, SA, 0, 0, "R5"); feed(1, SX, 0, 0, "R5 wait"); feed(1, SC, 0, 0, "R5 wait");
        feed(1, SX, 0, 0, "R5 wait"); feed(1, SB, 0, 0, "R5"); feed(1, SC, 0, 1, "R5 hit");

        // R6: inverted middle step
        wr_step(1, 9'h1FF, SB, 0, 1);
        feed(1, SA, 0, 0, "R6"); feed(1, SX, 0, 0, "R6 inverted pass"); feed(1, SC, 0, 1, "R6 hit");
        feed(1, SA, 0, 0, "R6"); feed(1, SB, 0, 0, "R6 inverted fail"); feed(1, SC, 0, 0, "R6 no hit");
        wr_step(1, 9'h1FF, SB, 0, 0);

        // R8: disqualify blocks the hit and restarts
        feed(1, SA, 0, 0, "R8"); feed(1, SB, 0, 0, "R8");
        feed(1, SC, 1, 0, "R8 disq"); feed(1, SC, 0, 0, "R8 after disq");
        feed(1, SA, 0, 0, "R8"); feed(1, SB, 0, 0, "R8"); feed(1, SC, 0, 1, "R8 recovered");

        // R10: symbol during a step write is dropped, position restarts
        feed(1, SA, 0, 0, "R10"); feed(1, SB, 0, 0, "R10");
        wr_step(3, 9'h000, 9'h000, 0, 0);
        sym_valid = 1'b1; sym_data = SC;
        #1;
        check(hit, 1'b0, "R10 write cycle");
        feed(1, SC, 0, 0, "R10 after write");

        // R9: length 0 is taken as 1
        wr_len(0);
        feed(1, SA, 0, 1, "R9 len1 hit"); feed(1, SX, 0, 0, "R9 len1 miss");
        feed(1, SA, 0, 1, "R9 len1 again");
        // R9: length above 16 is taken as 16
        wr_len(31);
        feed(1, SA, 0, 0, "R9"); feed(1, SB, 0, 0, "R9"); feed(1, SC, 0, 0, "R9");
        for (int i = 0; i < 12; i++) feed(1, SX, 0, 0, "R9 len16 fill");
        feed(1, SX, 0, 1, "R9 len16 hit");

        // Sweep: every 4-symbol word over {A,B,C,X}, all hold/invert settings of step 1
        wr_len(3);
        for (int hv = 0; hv < 4; hv++) begin
            logic [8:0] alpha [4];
            alpha[0] = SA; alpha[1] = SB; alpha[2] = SC; alpha[3] = SX;
            wr_step(1, 9'h1FF, SB, hv[1], hv[0]);
            for (int w = 0; w < 256; w++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [8:0] s;
                    s = alpha[(w >> (2 * k)) & 3];
                    if ((w + k) % 7 == 0) feed(0, s, 0, -1, "R7 sweep gap");
                    if (w % 37 == 5 && k == 0) feed(1, s, 1, -1, "R8 sweep disq");
                    feed(1, s, 0, -1, "R3 R4 R5 R6 sweep");
                end
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected finish before timeout");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule